// File: doc/BRIEF.md
# Fixed-Point Requantizer

The block narrows a fixed-point number from a wide input format to a narrower output format. Each format is fixed at elaboration by a total width and an integer width, and the difference between the two is the number of fractional bits. The value can be signed (two's complement, sign in the MSB) or unsigned. When the output keeps fewer fractional bits than the input, a rounding rule chosen at run time from seven rules decides the result. When the rounded value does not fit the output range, an overflow rule chosen at run time from five rules decides what is written.

Rounding is done first and range handling second. A carry out of rounding can therefore push a value out of range. The result is registered. Each accepted word gives one output word one clock later, together with a flag that reports a range violation. A typical use is after an accumulator in a filter or a neural-network layer, where a wide intermediate is stored back into a narrow data type.

Top module: `requant_unit`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `out_data` and `out_ovf` are all zero.
- R2: `out_valid` equals `in_valid` delayed by one clock. `out_data` and `out_ovf` are loaded only in cycles with `in_valid` high, and hold their values otherwise.
- R3: The input has `IN_W-IN_I` fractional bits and the output has `OUT_W-OUT_I`. With `q_mode` code 0 the dropped fractional bits are discarded, which truncates toward minus infinity. Code 7 behaves like code 0.
- R4: `q_mode` code 1 truncates toward zero: a negative input with nonzero dropped bits moves up by one output LSB.
- R5: The round-to-nearest codes differ only when the dropped part is exactly one half. Code 2 rounds a tie toward plus infinity, code 3 toward zero, code 4 toward minus infinity, and code 5 away from zero.
- R6: `q_mode` code 6 rounds to nearest and sends a tie to the even neighbour, the one whose output LSB is 0.
- R7: `out_ovf` is 1 exactly when the rounded value lies outside the output range, for every `o_mode`. A carry produced by rounding counts.
- R8: `o_mode` code 0 wraps: it keeps the low `OUT_W` bits of the rounded value. Codes 5, 6 and 7 behave like code 0.
- R9: `o_mode` code 1 saturates an out-of-range value to the largest or smallest output value.
- R10: `o_mode` code 2 outputs zero when the value is out of range. In-range values pass unchanged.
- R11: `o_mode` code 3 saturates symmetrically. For signed formats the results are clamped to ±max, so the most negative code is never produced. `out_ovf` still follows R7.
- R12: `o_mode` code 4 is the sign-magnitude wrap with zero saturation bits. If the sign bit of the wrapped word differs from the sign of the rounded value, the bitwise complement of the wrapped word is output. Otherwise the wrapped word is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | IN_W | Input fixed-point word |
| q_mode | input | 3 | Rounding rule code |
| o_mode | input | 3 | Overflow rule code |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_data | output | OUT_W | Requantized word |
| out_ovf | output | 1 | Rounded value was outside the output range |

## Verification
The rounding rules are driven with positive and negative exact ties, with a value just above a tie, and with an odd and an even truncated value. These inputs separate the seven rules, which agree on most other inputs. The overflow rules are tried with a large positive value, a large negative value and the most negative in-range value. This exposes the differences between saturation, symmetric saturation, zeroing, wrap and sign-magnitude wrap. A value just below the top of the range is rounded up across the boundary, to show that the flag and saturation act on the rounded value. Unused mode codes, reset and holding while `in_valid` is low are checked directly.

// File: rtl/requant_pkg.sv
package requant_pkg;

   typedef enum logic [2:0] {
      QM_TRN_NEG  = 3'd0,
      QM_TRN_ZERO = 3'd1,
      QM_RND_POS  = 3'd2,
      QM_RND_ZERO = 3'd3,
      QM_RND_NEG  = 3'd4,
      QM_RND_AWAY = 3'd5,
      QM_RND_EVEN = 3'd6
   } qmode_e;

   typedef enum logic [2:0] {
      OM_WRAP     = 3'd0,
      OM_SAT      = 3'd1,
      OM_SAT_ZERO = 3'd2,
      OM_SAT_SYM  = 3'd3,
      OM_WRAP_SM  = 3'd4
   } omode_e;

   function automatic qmode_e decode_qmode(input logic [2:0] code);
      qmode_e m;
      if (code == 3'd7) m = QM_TRN_NEG;
      else              m = qmode_e'(code);
      return m;
   endfunction

   function automatic omode_e decode_omode(input logic [2:0] code);
      omode_e m;
      if (code > 3'd4) m = OM_WRAP;
      else             m = omode_e'(code);
      return m;
   endfunction

endpackage

// File: rtl/requant_round.sv
module requant_round
   import requant_pkg::*;
#(
   parameter int IN_W   = 16,
   parameter int DROP   = 4,
   parameter bit SIGNED = 1'b1,
   localparam int QW    = IN_W + 2 - DROP
) (
   input  logic [IN_W-1:0]      din,
   input  qmode_e               mode,
   output logic signed [QW-1:0] q
);

   // one guard bit so unsigned values stay non-negative in signed arithmetic
   logic [IN_W:0] ext;
   assign ext = {(SIGNED ? din[IN_W-1] : 1'b0), din};

   generate
      if (DROP == 0) begin : g_pass
         assign q = signed'({ext[IN_W], ext});
      end else begin : g_drop
         localparam int TW = IN_W + 1 - DROP;
         logic [TW-1:0]   kept;
         logic [DROP-1:0] lost;
         logic            half;
         logic            above;
         logic            neg;
         logic            inexact;
         logic            bump;

         assign kept    = ext[IN_W:DROP];
         assign lost    = ext[DROP-1:0];
         assign half    = lost[DROP-1];
         assign neg     = ext[IN_W];
         assign inexact = |lost;

         if (DROP > 1) begin : g_below
            assign above = |lost[DROP-2:0];
         end else begin : g_nobelow
            assign above = 1'b0;
         end

         always_comb begin
            bump = 1'b0;
            unique case (mode)
               QM_TRN_NEG:  bump = 1'b0;
               QM_TRN_ZERO: bump = neg & inexact;
               QM_RND_POS:  bump = half;
               QM_RND_ZERO: bump = neg ? half : (half & above);
               QM_RND_NEG:  bump = half & above;
               QM_RND_AWAY: bump = neg ? (half & above) : half;
               QM_RND_EVEN: bump = half & (above | kept[0]);
               default:     bump = 1'b0;
            endcase
         end

         assign q = signed'({kept[TW-1], kept}) + signed'({{(QW-1){1'b0}}, bump});
      end
   endgenerate

endmodule

// File: rtl/requant_limit.sv
module requant_limit
   import requant_pkg::*;
#(
   parameter int QW     = 14,
   parameter int OUT_W  = 8,
   parameter bit SIGNED = 1'b1
) (
   input  logic signed [QW-1:0] q,
   input  omode_e               mode,
   output logic [OUT_W-1:0]     y,
   output logic                 ovf
);

   localparam int EXT = QW - OUT_W;
   localparam logic [OUT_W-1:0] HI_B = SIGNED ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}};
   localparam logic [OUT_W-1:0] LO_B = SIGNED ? {1'b1, {(OUT_W-1){1'b0}}} : {OUT_W{1'b0}};
   localparam logic signed [QW-1:0] HI_Q = {{EXT{1'b0}}, HI_B};
   localparam logic signed [QW-1:0] LO_Q = SIGNED ? {{EXT{1'b1}}, LO_B} : {QW{1'b0}};
   localparam logic signed [QW-1:0] SYM_Q = -HI_Q;

   logic             above_hi;
   logic             below_lo;
   logic [OUT_W-1:0] wrapped;
   logic [OUT_W-1:0] sat_v;
   logic [OUT_W-1:0] sym_v;
   logic [OUT_W-1:0] sm_v;

   assign above_hi = q > HI_Q;
   assign below_lo = q < LO_Q;
   assign ovf      = above_hi | below_lo;
   assign wrapped  = q[OUT_W-1:0];
   assign sat_v    = above_hi ? HI_B : (below_lo ? LO_B : wrapped);

   generate
      if (SIGNED) begin : g_signed
         logic below_sym;
         assign below_sym = q < SYM_Q;
         assign sym_v = above_hi ? HI_B : (below_sym ? SYM_Q[OUT_W-1:0] : wrapped);
         assign sm_v  = (wrapped[OUT_W-1] != q[QW-1]) ? ~wrapped : wrapped;
      end else begin : g_unsigned
         assign sym_v = sat_v;
         assign sm_v  = wrapped;
      end
   endgenerate

   always_comb begin
      y = wrapped;
      unique case (mode)
         OM_WRAP:     y = wrapped;
         OM_SAT:      y = sat_v;
         OM_SAT_ZERO: y = ovf ? {OUT_W{1'b0}} : wrapped;
         OM_SAT_SYM:  y = sym_v;
         OM_WRAP_SM:  y = sm_v;
         default:     y = wrapped;
      endcase
   end

endmodule

// File: rtl/requant_unit.sv
module requant_unit
   import requant_pkg::*;
#(
   parameter int IN_W   = 16,
   parameter int IN_I   = 8,
   parameter int OUT_W  = 8,
   parameter int OUT_I  = 4,
   parameter bit SIGNED = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   input  logic [2:0]       q_mode,
   input  logic [2:0]       o_mode,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data,
   output logic             out_ovf
);

   localparam int IN_F  = IN_W - IN_I;
   localparam int OUT_F = OUT_W - OUT_I;
   localparam int DROP  = IN_F - OUT_F;
   localparam int QW    = IN_W + 2 - DROP;

   generate
      if (OUT_W < 2 || IN_W < OUT_W) begin : g_bad_width
         $error("requant_unit: widths must satisfy 2 <= OUT_W <= IN_W");
      end
      if (DROP < 0) begin : g_bad_frac
         $error("requant_unit: output may not have more fractional bits than input");
      end
      if (IN_I < OUT_I) begin : g_bad_int
         $error("requant_unit: output may not have more integer bits than input");
      end
   endgenerate

   qmode_e           qm;
   omode_e           om;
   logic [QW-1:0]    rounded;
   logic [OUT_W-1:0] limited;
   logic             range_err;

   assign qm = decode_qmode(q_mode);
   assign om = decode_omode(o_mode);

   requant_round #(
      .IN_W   (IN_W),
      .DROP   (DROP),
      .SIGNED (SIGNED)
   ) u_round (
      .din  (in_data),
      .mode (qm),
      .q    (rounded)
   );

   requant_limit #(
      .QW     (QW),
      .OUT_W  (OUT_W),
      .SIGNED (SIGNED)
   ) u_limit (
      .q    (rounded),
      .mode (om),
      .y    (limited),
      .ovf  (range_err)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_ovf   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= limited;
            out_ovf  <= range_err;
         end
      end
   end

endmodule

// File: rtl/requant_unit_chk.sv
module requant_unit_chk #(
   parameter int OUT_W  = 8,
   parameter bit SIGNED = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [2:0]       o_mode,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_data,
   input logic             out_ovf
);

   localparam logic [OUT_W-1:0] TOP = SIGNED ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}};
   localparam logic [OUT_W-1:0] BOT = SIGNED ? {1'b1, {(OUT_W-1){1'b0}}} : {OUT_W{1'b0}};

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R2

   AST_VALID_ONLY_AFTER_INPUT: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R2

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_data) && $stable(out_ovf))); // R2

   AST_SAT_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
      (in_valid && o_mode == 3'd1) |=> (!out_ovf || out_data == TOP || out_data == BOT)); // R9

   AST_ZERO_ON_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (in_valid && o_mode == 3'd2) |=> (!out_ovf || out_data == '0)); // R10

   AST_SYM_NO_MOST_NEG: assert property (@(posedge clk) disable iff (rst)
      (in_valid && o_mode == 3'd3 && SIGNED) |=> (out_data != BOT)); // R11

endmodule

bind requant_unit requant_unit_chk #(
   .OUT_W  (OUT_W),
   .SIGNED (SIGNED)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .o_mode    (o_mode),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_ovf   (out_ovf)
);

// File: tb/requant_unit_test.sv
module requant_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 29;

   // {q_mode, o_mode, in_data (Q8.8), expected out_data (Q4.4), expected out_ovf}
   localparam logic [30:0] VEC [NV] = '{
      {3'd0, 3'd0, 16'h0128, 8'h12, 1'b0},  // R3  +18.5 units, truncate
      {3'd1, 3'd0, 16'h0128, 8'h12, 1'b0},  // R4
      {3'd2, 3'd0, 16'h0128, 8'h13, 1'b0},  // R5  tie up
      {3'd3, 3'd0, 16'h0128, 8'h12, 1'b0},  // R5  tie to zero
      {3'd4, 3'd0, 16'h0128, 8'h12, 1'b0},  // R5  tie down
      {3'd5, 3'd0, 16'h0128, 8'h13, 1'b0},  // R5  tie away
      {3'd6, 3'd0, 16'h0128, 8'h12, 1'b0},  // R6  even stays
      {3'd6, 3'd0, 16'h0138, 8'h14, 1'b0},  // R6  odd goes up
      {3'd0, 3'd0, 16'hFED8, 8'hED, 1'b0},  // R3  -18.5 units
      {3'd1, 3'd0, 16'hFED8, 8'hEE, 1'b0},  // R4
      {3'd2, 3'd0, 16'hFED8, 8'hEE, 1'b0},  // R5
      {3'd3, 3'd0, 16'hFED8, 8'hEE, 1'b0},  // R5
      {3'd4, 3'd0, 16'hFED8, 8'hED, 1'b0},  // R5
      {3'd5, 3'd0, 16'hFED8, 8'hED, 1'b0},  // R5
      {3'd6, 3'd0, 16'hFED8, 8'hEE, 1'b0},  // R6
      {3'd0, 3'd0, 16'h0A00, 8'hA0, 1'b1},  // R8  +10.0 wraps
      {3'd0, 3'd1, 16'h0A00, 8'h7F, 1'b1},  // R9
      {3'd0, 3'd2, 16'h0A00, 8'h00, 1'b1},  // R10
      {3'd0, 3'd3, 16'h0A00, 8'h7F, 1'b1},  // R11
      {3'd0, 3'd4, 16'h0A00, 8'h5F, 1'b1},  // R12
      {3'd0, 3'd1, 16'hF600, 8'h80, 1'b1},  // R9  -10.0
      {3'd0, 3'd3, 16'hF600, 8'h81, 1'b1},  // R11
      {3'd0, 3'd4, 16'hF600, 8'h9F, 1'b1},  // R12
      {3'd0, 3'd3, 16'hF800, 8'h81, 1'b0},  // R11 -8.0 in range
      {3'd2, 3'd1, 16'h07F8, 8'h7F, 1'b1},  // R7  rounding carry overflows
      {3'd0, 3'd1, 16'h07F8, 8'h7F, 1'b0},  // R7  truncation stays in range
      {3'd7, 3'd6, 16'h0A08, 8'hA0, 1'b1},  // R3 R8 unused codes
      {3'd4, 3'd0, 16'h012C, 8'h13, 1'b0},  // R5  above tie
      {3'd0, 3'd2, 16'h0128, 8'h12, 1'b0}   // R10 in range passes
   };
   localparam int VREQ [NV] = '{3,4,5,5,5,5,6,6,3,4,5,5,5,5,6,8,9,10,11,12,9,11,12,11,7,7,3,5,10};

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [15:0] in_data;
   logic [2:0]  q_mode;
   logic [2:0]  o_mode;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        out_ovf;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   requant_unit uut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .q_mode    (q_mode),
      .o_mode    (o_mode),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_ovf   (out_ovf)
   );

   task automatic check(input int req, input logic [8:0] act, input logic [8:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_data = '0; q_mode = '0; o_mode = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check(1, {out_valid, out_data}, 9'h000, "reset valid/data");
      check(1, {8'h00, out_ovf}, 9'h000, "reset ovf");

      for (int i = 0; i < NV; i++) begin
         q_mode   = VEC[i][30:28];
         o_mode   = VEC[i][27:25];
         in_data  = VEC[i][24:9];
         in_valid = 1'b1;
         @(negedge clk);
         check(VREQ[i], {out_ovf, out_data}, {VEC[i][0], VEC[i][8:1]}, $sformatf("vector %0d", i));
         check(2, {8'h00, out_valid}, 9'h001, $sformatf("valid after vector %0d", i));
      end

      // R2 hold while idle: different data, no strobe
      in_valid = 1'b0;
      in_data  = 16'h0A00;
      o_mode   = 3'd0;
      q_mode   = 3'd0;
      @(negedge clk);
      check(2, {out_ovf, out_data}, 9'h012, "hold data while idle");
      check(2, {8'h00, out_valid}, 9'h000, "valid drops");
      @(negedge clk);
      check(2, {out_ovf, out_data}, 9'h012, "hold data second idle cycle");

      // R2 single strobe then gap
      in_valid = 1'b1;
      in_data  = 16'hF600;
      o_mode   = 3'd0;
      @(negedge clk);
      in_valid = 1'b0;
      check(8, {out_ovf, out_data}, 9'h160, "wrap negative");
      @(negedge clk);
      check(2, {8'h00, out_valid}, 9'h000, "no valid after gap");

      // R1 reset mid-run clears outputs
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(1, {out_ovf, out_data}, 9'h000, "reset clears result");
      check(1, {8'h00, out_valid}, 9'h000, "reset clears valid");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule